// File: doc/BRIEF.md
# Audio DMA Counter Register Bank

This block is a byte-wide indexed register bank for an audio controller. It keeps two 16-bit transfer counters, one for playback and one for recording. The host preloads each counter through an index/data write port. It can read back the live count at any time, so a driver can save the count on suspend and restore it on resume. Each channel has a decrement strobe that pulses once per transferred byte. When a counter steps past zero, it reloads from its last programmed base and raises that channel's interrupt flag.

A separate injection index lets the host force any of the three interrupt flags (timer, capture, playback), and a clear index removes them. The IRQ output is the OR of the flags, gated by an external interrupt-enable input. A miscellaneous register holds two control bits, the live state of an operating-mode input and a fixed version code.

Top module: `audio_dma_regbank`

## Requirements
- R1: After reset, all four counter bytes read FFh, the flag register (index 0Fh) reads 00h, the misc register (index 0Ah) reads 84h with mode_stat low, and irq is 0.
- R2: A write to a counter low index (0Bh playback, 0Dh recording) goes only to a staging register; the live count, as read back, does not change.
- R3: A write to a counter high index (0Ch playback, 0Eh recording) loads the count with {written byte, staged low byte} on that clock edge. The same value becomes the reload base.
- R4: Reading a counter index returns the corresponding byte of the live count (low index bits 7:0, high index bits 15:8), including while decrementing.
- R5: Each cycle with a channel's decrement strobe high and a nonzero count lowers that count by one.
- R6: A decrement strobe while the count is 0000h reloads the count from the base and sets that channel's flag: playback sets bit 0 and recording sets bit 1 of the flag register.
- R7: Writing index 0Fh sets every flag whose data bit is 1 (bit 2 timer, bit 1 capture, bit 0 playback). Flags written 0 are left unchanged. Reading 0Fh returns the flags in bits 2:0.
- R8: Writing index 10h clears every flag whose data bit is 1 and leaves the others.
- R9: irq is 1 exactly when irq_en is 1 and at least one flag is set.
- R10: In the misc register, bit 7 (volume-control enable, reset 1) and bit 3 (loopback source select, reset 0) are writable. Bit 4 reads mode_stat, bits 2:0 read 100b, and bits 6:5 read 0. Writes to the read-only bits have no effect.
- R11: A high-byte write in the same cycle as a decrement strobe on that channel loads the written value; the decrement is dropped.
- R12: A flag set (wrap or injection) in the same cycle as a clear of that flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx | input | IDX_W | Register index for both write and read |
| wr_en | input | 1 | Write strobe for wdata at idx |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data at idx (combinational) |
| dec_play | input | 1 | Playback byte-transferred strobe |
| dec_rec | input | 1 | Recording byte-transferred strobe |
| irq_en | input | 1 | Interrupt enable |
| mode_stat | input | 1 | Operating-mode status shown in misc bit 4 |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default DATA_W=8 and IDX_W=8. Full 16-bit counts therefore keep their real byte split, and borrows across the byte boundary are exercised. Short base values (0 through 40) keep whole count-down-and-wrap cycles within a few hundred clocks, so every wrap in the sweep is checked arithmetically. Collisions between a load and a strobe, and between a set and a clear, are driven directly at the ports.

// File: rtl/audio_dma_pkg.sv
package audio_dma_pkg;
   localparam logic [7:0] IDX_MISC    = 8'h0A;
   localparam logic [7:0] IDX_PLAY_LO = 8'h0B;
   localparam logic [7:0] IDX_PLAY_HI = 8'h0C;
   localparam logic [7:0] IDX_REC_LO  = 8'h0D;
   localparam logic [7:0] IDX_REC_HI  = 8'h0E;
   localparam logic [7:0] IDX_FORCE   = 8'h0F;
   localparam logic [7:0] IDX_CLEAR   = 8'h10;

   localparam int N_CHAN  = 2;   // channel 0 playback, channel 1 recording
   localparam int N_FLAGS = 3;   // bit2 timer, bit1 capture, bit0 playback

   localparam int MISC_VOL_BIT  = 7;
   localparam int MISC_MODE_BIT = 4;
   localparam int MISC_LOOP_BIT = 3;
endpackage

// File: rtl/adrb_chan_counter.sv
module adrb_chan_counter #(
   parameter int DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_lo,
   input  logic                  wr_hi,
   input  logic [DATA_W-1:0]     wdata,
   input  logic                  dec,
   output logic [2*DATA_W-1:0]   count,
   output logic                  wrap
);
   localparam int CNT_W = 2 * DATA_W;

   logic [DATA_W-1:0] stage_q;
   logic [CNT_W-1:0]  base_q;

   assign wrap = dec && !wr_hi && (count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= '1;
         base_q  <= '1;
         count   <= '1;
      end else begin
         if (wr_lo) stage_q <= wdata;
         if (wr_hi) begin
            base_q <= {wdata, stage_q};
            count  <= {wdata, stage_q};
         end else if (dec) begin
            count <= wrap ? base_q : count - 1'b1;
         end
      end
   end

   p_stage_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi && !dec) |=> $stable(count));
   p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> (count == {$past(wdata), $past(stage_q)}));
   p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !wr_hi && count != '0) |=> (count == $past(count) - 1'b1));
   p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !wr_hi && count == '0) |=> (count == $past(base_q)));
   p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && dec) |=> (count == base_q));
endmodule

// File: rtl/adrb_irq_flags.sv
module adrb_irq_flags #(
   parameter int N_FLAGS = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_FLAGS-1:0] set_vec,
   input  logic [N_FLAGS-1:0] clr_vec,
   input  logic               irq_en,
   output logic [N_FLAGS-1:0] flags,
   output logic               irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr_vec) | set_vec;
   end

   assign irq = irq_en && (|flags);

   p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_vec & ~set_vec)) |=> ((flags & $past(clr_vec & ~set_vec)) == '0));
   p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);
   p_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flags != '0));
   p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_vec & clr_vec)) |=>
         ((flags & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));
endmodule

// File: rtl/audio_dma_regbank.sv
module audio_dma_regbank
   import audio_dma_pkg::*;
#(
   parameter int         DATA_W  = 8,
   parameter int         IDX_W   = 8,
   parameter logic [2:0] VERSION = 3'b100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              dec_play,
   input  logic              dec_rec,
   input  logic              irq_en,
   input  logic              mode_stat,
   output logic              irq
);
   localparam int CNT_W = 2 * DATA_W;

   if (DATA_W < 8) begin : g_bad_data_w
      $error("DATA_W must be at least 8");
   end
   if (IDX_W < 5) begin : g_bad_idx_w
      $error("IDX_W must be at least 5");
   end

   logic [CNT_W-1:0]   cnt  [N_CHAN];
   logic [N_CHAN-1:0]  wrap;
   logic [N_CHAN-1:0]  dec_vec;
   logic [N_FLAGS-1:0] flags, set_vec, clr_vec;
   logic               vol_q, loop_q;

   assign dec_vec = {dec_rec, dec_play};

   for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
      localparam logic [7:0] LO = IDX_PLAY_LO + 8'(2 * c);
      localparam logic [7:0] HI = LO + 8'd1;
      adrb_chan_counter #(.DATA_W(DATA_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_lo (wr_en && idx == IDX_W'(LO)),
         .wr_hi (wr_en && idx == IDX_W'(HI)),
         .wdata (wdata),
         .dec   (dec_vec[c]),
         .count (cnt[c]),
         .wrap  (wrap[c])
      );
   end

   always_comb begin
      set_vec = '0;
      clr_vec = '0;
      set_vec[N_CHAN-1:0] = wrap;
      if (wr_en && idx == IDX_W'(IDX_FORCE)) set_vec = set_vec | wdata[N_FLAGS-1:0];
      if (wr_en && idx == IDX_W'(IDX_CLEAR)) clr_vec = wdata[N_FLAGS-1:0];
   end

   adrb_irq_flags #(.N_FLAGS(N_FLAGS)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .irq_en  (irq_en),
      .flags   (flags),
      .irq     (irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vol_q  <= 1'b1;
         loop_q <= 1'b0;
      end else if (wr_en && idx == IDX_W'(IDX_MISC)) begin
         vol_q  <= wdata[MISC_VOL_BIT];
         loop_q <= wdata[MISC_LOOP_BIT];
      end
   end

   always_comb begin
      rdata = '0;
      unique case (idx)
         IDX_W'(IDX_MISC): begin
            rdata[MISC_VOL_BIT]  = vol_q;
            rdata[MISC_MODE_BIT] = mode_stat;
            rdata[MISC_LOOP_BIT] = loop_q;
            rdata[2:0]           = VERSION;
         end
         IDX_W'(IDX_PLAY_LO): rdata = cnt[0][DATA_W-1:0];
         IDX_W'(IDX_PLAY_HI): rdata = cnt[0][CNT_W-1:DATA_W];
         IDX_W'(IDX_REC_LO):  rdata = cnt[1][DATA_W-1:0];
         IDX_W'(IDX_REC_HI):  rdata = cnt[1][CNT_W-1:DATA_W];
         IDX_W'(IDX_FORCE):   rdata[N_FLAGS-1:0] = flags;
         default:             rdata = '0;
      endcase
   end

   p_misc_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == IDX_W'(IDX_MISC)) |=>
         (vol_q == $past(wdata[MISC_VOL_BIT]) && loop_q == $past(wdata[MISC_LOOP_BIT])));
   p_misc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && idx == IDX_W'(IDX_MISC)) |=> ($stable(vol_q) && $stable(loop_q)));
endmodule

// File: tb/audio_dma_regbank_tb_top.sv
module audio_dma_regbank_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] idx = 8'h00;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       dec_play = 1'b0, dec_rec = 1'b0;
   logic       irq_en = 1'b0, mode_stat = 1'b0;
   logic       irq;
   int         n_chk = 0, n_err = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   audio_dma_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .idx(idx), .wr_en(wr_en), .wdata(wdata),
      .rdata(rdata), .dec_play(dec_play), .dec_rec(dec_rec),
      .irq_en(irq_en), .mode_stat(mode_stat), .irq(irq)
   );

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] i, input logic [7:0] d);
      @(negedge clk);
      idx = i; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] i, output logic [7:0] v);
      idx = i;
      #1;
      v = rdata;
   endtask

   task automatic rd16(input bit rec, output logic [15:0] v);
      logic [7:0] lo, hi;
      rd(rec ? 8'h0D : 8'h0B, lo);
      rd(rec ? 8'h0E : 8'h0C, hi);
      v = {hi, lo};
   endtask

   task automatic load(input bit rec, input logic [15:0] val);
      wr(rec ? 8'h0D : 8'h0B, val[7:0]);
      wr(rec ? 8'h0E : 8'h0C, val[15:8]);
   endtask

   task automatic pulse(input bit rec, input int n);
      if (n > 0) begin
         @(negedge clk);
         if (rec) dec_rec = 1'b1; else dec_play = 1'b1;
         repeat (n) @(negedge clk);
         dec_rec = 1'b0; dec_play = 1'b0;
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: got %h expected %h", 16'h0, 16'h1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0]  v;
      logic [15:0] c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int i = 8'h0B; i <= 8'h0E; i++) begin
         rd(8'(i), v); chk("R1 counter byte", 16'(v), 16'hFF);
      end
      rd(8'h0A, v); chk("R1 misc", 16'(v), 16'h84);
      rd(8'h0F, v); chk("R1 flags", 16'(v), 16'h00);
      chk("R1 irq", 16'(irq), 16'h0);

      // R2 staging, R3 load
      wr(8'h0B, 8'h34);
      rd16(1'b0, c); chk("R2 low write staged only", c, 16'hFFFF);
      wr(8'h0C, 8'h12);
      rd16(1'b0, c); chk("R3 high write loads", c, 16'h1234);

      // R4 R5 live readback while decrementing, borrow across byte
      pulse(1'b0, 5);
      rd16(1'b0, c); chk("R4 R5 live count", c, 16'h122F);
      load(1'b0, 16'h0100);
      pulse(1'b0, 1);
      rd16(1'b0, c); chk("R5 borrow", c, 16'h00FF);
      rd16(1'b1, c); chk("R5 other channel untouched", c, 16'hFFFF);

      // R6 sweep of wrap on both channels
      for (int ch = 0; ch < 2; ch++) begin
         for (int l = 0; l <= 40; l++) begin
            load(ch[0], 16'(l));
            pulse(ch[0], l);
            rd16(ch[0], c); chk("R5 count reaches zero", c, 16'h0000);
            rd(8'h0F, v); chk("R6 no flag before wrap", 16'(v), 16'h0);
            pulse(ch[0], 1);
            rd16(ch[0], c); chk("R6 reload from base", c, 16'(l));
            rd(8'h0F, v); chk("R6 channel flag", 16'(v), ch == 0 ? 16'h1 : 16'h2);
            wr(8'h10, 8'h07);
            rd(8'h0F, v); chk("R8 clear all", 16'(v), 16'h0);
         end
      end

      // R7 injection, R8 selective clear, R9 gating
      wr(8'h0F, 8'h04);
      rd(8'h0F, v); chk("R7 timer set", 16'(v), 16'h4);
      chk("R9 irq gated off", 16'(irq), 16'h0);
      irq_en = 1'b1; #1;
      chk("R9 irq enabled", 16'(irq), 16'h1);
      wr(8'h0F, 8'h03);
      rd(8'h0F, v); chk("R7 add flags keeps others", 16'(v), 16'h7);
      wr(8'h10, 8'h05);
      rd(8'h0F, v); chk("R8 selective clear", 16'(v), 16'h2);
      chk("R9 irq with capture flag", 16'(irq), 16'h1);
      wr(8'h10, 8'h02);
      chk("R9 irq drops", 16'(irq), 16'h0);
      irq_en = 1'b0;

      // R10 misc bits
      wr(8'h0A, 8'hFF);
      rd(8'h0A, v); chk("R10 write all ones", 16'(v), 16'h8C);
      mode_stat = 1'b1;
      rd(8'h0A, v); chk("R10 mode bit", 16'(v), 16'h9C);
      wr(8'h0A, 8'h00);
      rd(8'h0A, v); chk("R10 write zeros", 16'(v), 16'h14);
      mode_stat = 1'b0;

      // R11 load beats decrement
      load(1'b1, 16'h0009);
      wr(8'h0D, 8'h50);
      @(negedge clk);
      idx = 8'h0E; wdata = 8'h00; wr_en = 1'b1; dec_rec = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; dec_rec = 1'b0;
      rd16(1'b1, c); chk("R11 load wins", c, 16'h0050);

      // R12 wrap set beats clear
      load(1'b0, 16'h0000);
      @(negedge clk);
      idx = 8'h10; wdata = 8'h01; wr_en = 1'b1; dec_play = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; dec_play = 1'b0;
      rd(8'h0F, v); chk("R12 set wins", 16'(v), 16'h1);
      rd16(1'b0, c); chk("R6 reload zero base", c, 16'h0000);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule